// File: doc/BRIEF.md
# Scanline-Clocked Interrupt Counter

This block counts rendered video lines and raises a level interrupt toward the CPU once a programmed number of them have passed. The CPU programs it by writing four registers. One write loads the live counter. One loads a reload value. The other two switch counting off and on. Any of these four writes also acknowledges a pending interrupt.

Line timing comes from an external pulse, `line_tick`, which fires once per scanline and carries the line number with it. A separate flag says whether rendering is active. On each qualifying line the counter is tested first and decremented after. A zero value fires the interrupt and reloads the counter. While the interrupt is pending, counting is frozen. On line 0, a nonzero counter loses one additional count before the normal test.

Top module: `scanline_irq_counter`

## Requirements
- R1: After reset, `irq_out` is 0, counting is disabled, and both the counter and the reload value are 0.
- R2: A write to address 0xC000 loads the counter with `cpu_wdata`.
- R3: A write to 0xC001 loads the reload value. When the interrupt fires, the counter takes the reload value.
- R4: A write to 0xE000 disables counting. A write to 0xE001 enables it. The data byte is ignored for both.
- R5: A write to any of 0xC000, 0xC001, 0xE000 or 0xE001 clears a pending interrupt, so `irq_out` is 0 in the next cycle.
- R6: A line is counted only when all of these hold: `line_num` is at most LAST_LINE (239 by default), `render_on` is 1, counting is enabled, and no interrupt is pending. Any other tick leaves all state unchanged.
- R7: On a counted line, a counter value of 0 sets the pending interrupt, and `irq_out` goes to 1 in the next cycle. Any other value is decremented by one. A counter loaded with N on a line other than 0 therefore fires on its (N+1)th counted line.
- R8: On a counted line whose number is 0, a nonzero counter is decremented once before the zero test. A counter of 1 therefore fires on line 0.
- R9: Address bit 11 is ignored when decoding, so 0xC800 acts as 0xC000. Writes to any other address have no effect.
- R10: When a register write and a line tick arrive in the same cycle, the write takes effect and the tick is not counted.
- R11: Once `irq_out` is 1, it stays at 1 until one of the four register writes acknowledges it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | One-cycle CPU write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | CNT_W | CPU write data |
| line_tick | input | 1 | One-cycle pulse, once per scanline |
| line_num | input | LINE_W | Number of the current scanline |
| render_on | input | 1 | Rendering is enabled |
| irq_out | output | 1 | Level interrupt request, active high |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, 9-bit line numbers and a last counted line of 239. With these values the bench can drive line numbers above the counted range as well as the 0-to-239 range, which exercises the line gate and the line-0 extra decrement. The full 8-bit counter range is also within reach: one directed run loads 255 and counts it down across line numbers without reaching line 0.

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter #(
  parameter int CNT_W     = 8,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [15:0]       cpu_addr,
  input  logic [CNT_W-1:0]  cpu_wdata,
  input  logic              line_tick,
  input  logic [LINE_W-1:0] line_num,
  input  logic              render_on,
  output logic              irq_out
);
  localparam logic [15:0]       DEC_MASK = 16'hF7FF;
  localparam logic [LINE_W-1:0] LAST     = LINE_W'(LAST_LINE);
  localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0]  ZERO     = '0;

  logic [CNT_W-1:0] cnt_q, lat_q, pre;
  logic             en_q, pend_q;
  logic [15:0]      a;
  logic             wr_cnt, wr_lat, wr_off, wr_on, hit, step, fire;

  assign a      = cpu_addr & DEC_MASK;
  assign wr_cnt = cpu_we && (a == 16'hC000);
  assign wr_lat = cpu_we && (a == 16'hC001);
  assign wr_off = cpu_we && (a == 16'hE000);
  assign wr_on  = cpu_we && (a == 16'hE001);
  assign hit    = wr_cnt | wr_lat | wr_off | wr_on;

  assign step = line_tick && render_on && en_q && !pend_q && (line_num <= LAST) && !hit;
  assign pre  = (line_num == '0 && cnt_q != ZERO) ? cnt_q - ONE : cnt_q;
  assign fire = step && (pre == ZERO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lat_q  <= '0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_cnt) cnt_q <= cpu_wdata;
      if (wr_lat) lat_q <= cpu_wdata;
      if (wr_off) en_q  <= 1'b0;
      if (wr_on)  en_q  <= 1'b1;
      if (hit) begin
        pend_q <= 1'b0;
      end else if (fire) begin
        pend_q <= 1'b1;
        cnt_q  <= lat_q;
      end else if (step) begin
        cnt_q  <= pre - ONE;
      end
    end
  end

  assign irq_out = pend_q;

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !irq_out); // R5
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !hit) |=> irq_out); // R11
  AST_OFF_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !hit) |=> !$rose(irq_out)); // R4
  AST_LINE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_num > LAST && !hit) |=> $stable(cnt_q) && $stable(pend_q)); // R6
  AST_FIRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> cnt_q == lat_q); // R3
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && line_tick) |=> !irq_out); // R10
endmodule

// File: tb/scanline_irq_counter_test.sv
module scanline_irq_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic       line_tick = 1'b0;
  logic [8:0] line_num = '0;
  logic       render_on = 1'b0;
  logic       irq_out;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [7:0] m_cnt, m_lat;
  logic       m_en, m_pend;

  always #2.5 clk = ~clk;

  scanline_irq_counter uut (.*);

  function automatic bit is_reg(input logic [15:0] ad);
    logic [15:0] x = ad & 16'hF7FF;
    return x == 16'hC000 || x == 16'hC001 || x == 16'hE000 || x == 16'hE001;
  endfunction

  task automatic model(input logic we, input logic [15:0] ad, input logic [7:0] d,
                       input logic tk, input logic [8:0] ln, input logic rd);
    logic [15:0] x = ad & 16'hF7FF;
    logic [7:0]  p;
    if (we && is_reg(ad)) begin
      if (x == 16'hC000) m_cnt = d;
      if (x == 16'hC001) m_lat = d;
      if (x == 16'hE000) m_en = 0;
      if (x == 16'hE001) m_en = 1;
      m_pend = 0;
    end else if (tk && rd && m_en && !m_pend && ln <= 239) begin
      p = (ln == 0 && m_cnt != 0) ? m_cnt - 8'd1 : m_cnt;
      if (p == 0) begin m_pend = 1; m_cnt = m_lat; end
      else m_cnt = p - 8'd1;
    end
  endtask

  task automatic cyc(input logic we, input logic [15:0] ad, input logic [7:0] d,
                     input logic tk, input logic [8:0] ln, input logic rd, input string tag);
    cpu_we = we; cpu_addr = ad; cpu_wdata = d;
    line_tick = tk; line_num = ln; render_on = rd;
    model(we, ad, d, tk, ln, rd);
    @(posedge clk);
    @(negedge clk);
    cpu_we = 0; line_tick = 0;
    checks++;
    if (irq_out !== m_pend) begin
      errors++;
      $display("FAIL %s: irq_out=%b expected %b", tag, irq_out, m_pend);
    end
  endtask

  task automatic wr(input logic [15:0] ad, input logic [7:0] d, input string tag);
    cyc(1, ad, d, 0, 9'd0, 1, tag);
  endtask

  task automatic tick(input logic [8:0] ln, input logic rd, input string tag);
    cyc(0, 16'h0000, 8'h00, 1, ln, rd, tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: expired, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_cnt = 0; m_lat = 0; m_en = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    checks++;
    if (irq_out !== 1'b0) begin errors++; $display("FAIL R1: irq_out=%b expected 0", irq_out); end
    // R1: disabled after reset, so a tick does nothing
    tick(9'd5, 1, "R1 disabled");
    // R1: counter and reload are zero, so enabling fires on the first line
    wr(16'hE001, 8'h00, "R4 enable");
    tick(9'd5, 1, "R1 zero counter fires");
    tick(9'd6, 1, "R11 holds");
    tick(9'd7, 1, "R11 holds");
    wr(16'hC001, 8'h02, "R5 ack via latch");
    // R2/R7: load 3, fires on fourth counted line
    wr(16'hC000, 8'h03, "R2 load");
    for (int i = 0; i < 5; i++) tick(9'(10 + i), 1, "R7 count");
    // R3: reload 2 -> fires after 3 more lines
    wr(16'hE001, 8'h00, "R5 ack via enable");
    for (int i = 0; i < 4; i++) tick(9'(20 + i), 1, "R3 reload");
    // R6 gating
    wr(16'hC000, 8'h01, "R2 load");
    tick(9'd240, 1, "R6 line 240");
    tick(9'd300, 1, "R6 line 300");
    tick(9'd30, 0, "R6 render off");
    tick(9'd239, 1, "R6 line 239");
    tick(9'd200, 1, "R6 fire");
    tick(9'd201, 1, "R6 pending freeze");
    // R8: line 0 extra decrement
    wr(16'hC000, 8'h01, "R8 load");
    tick(9'd0, 1, "R8 fires on line 0");
    wr(16'hC000, 8'h03, "R8 load");
    tick(9'd0, 1, "R8 3 to 1");
    tick(9'd1, 1, "R8 1 to 0");
    tick(9'd2, 1, "R8 fire");
    // R4 disable, data ignored
    wr(16'hE000, 8'hFF, "R4 disable");
    wr(16'hC000, 8'h00, "R4 load 0");
    tick(9'd50, 1, "R4 no count while off");
    wr(16'hE001, 8'h00, "R4 enable");
    tick(9'd51, 1, "R4 counts");
    // R9 decode
    wr(16'hC800, 8'h02, "R9 mirror load");
    wr(16'hC002, 8'h00, "R9 other addr");
    tick(9'd60, 1, "R9 count");
    tick(9'd61, 1, "R9 count");
    tick(9'd62, 1, "R9 fire");
    wr(16'hA000, 8'h00, "R9 no ack");
    wr(16'hE801, 8'h00, "R9 mirror ack");
    // R10 write with tick
    cyc(1, 16'hC000, 8'h00, 1, 9'd70, 1, "R10 write wins");
    tick(9'd71, 1, "R10 then fires");
    wr(16'hC000, 8'hFF, "R7 full range");
    for (int i = 0; i < 257; i++) tick(9'(1 + (i % 239)), 1, "R7 255 count");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r = $urandom;
      logic [15:0] ad;
      case (r[2:0])
        3'd0: ad = 16'hC000; 3'd1: ad = 16'hC001; 3'd2: ad = 16'hE000;
        3'd3: ad = 16'hE001; default: ad = 16'(r[31:16]);
      endcase
      if (r[3]) ad[11] = 1'b1;
      cyc(r[6:4] == 0, ad, 8'(r[15:8] & 8'h07), r[7] | r[8], 9'(r[24:16] % 9'd260),
          r[9:8] != 2'b00, "R7 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial void'($urandom(32'd12345));
endmodule